// File: doc/BRIEF.md
# Interleaved ECC Correction Status Controller

This block sits beside a three-way interleaved Reed-Solomon style decoder. It turns the decoder's per-sector results into control and status for a local microprocessor. The decoder supplies a saturating error count for each interleave, an uncorrectable indication and a strobe at the end of the ECC field. The block tallies error bytes per sector against a log threshold. It applies a programmable early-warning threshold and a programmable automatic-correction threshold. It then walks the interleaves in descending order (2, 1, 0) and either issues an automatic-fix pulse for each one or stalls for software help.

When an interleave holds more errors than the automatic limit allows, correction halts and a software-required flag rises. While that flag is set, the disk-to-buffer transfer count is held off. The processor services the interleave and then acknowledges with a self-clearing rotate pulse. That pulse releases the stall and moves the walk to the next interleave. A full reset input holds every register, including configuration, in reset. A lighter correction reset clears only the sector state and the flags.

Top module: `ecc_corr_status`

## Requirements
- R1: `log_cnt` counts cycles with `err_byte` high while a sector is open and saturates at 15. It reads 0 on the cycle after an accepted `sec_start` and after `rst_corr`.
- R2: `thexc` sets at an accepted `field_end` when `log_cnt` is strictly greater than the log threshold and `uncorr_in` is low. A threshold of 15 therefore never sets it. It clears on `thexc_w1c` or `rst_corr`.
- R3: The early-warning field is `cfg_wdata[3:2]`. With 00, `ewarn` never sets. With value k ≠ 0, `ewarn` sets at an accepted `field_end` when `uncorr_in` is low and any interleave count is ≥ k. It is sticky until a reset.
- R4: The correction limit is `cfg_wdata[1:0]`. While the walk visits an interleave with count n, where 0 < n ≤ limit, `auto_fix` is high for that one cycle. A limit of 00 never fixes automatically.
- R5: While the walk visits an interleave whose count exceeds the limit, `sw_req` rises on the next cycle and the walk holds on that interleave. While `sw_req` is high, `xfer_cnt_en` is low even with `xfer_req` high.
- R6: A `rotate_wr` pulse while stalled clears `sw_req` on the next cycle. The same pulse moves the walk to the next lower interleave, or ends it after interleave 0.
- R7: `curr_intl` is 0, 1 or 2 for the visited interleave and 3 when none is visited. `num_err` is that interleave's count, with 3 meaning three or more, and 0 when none is visited. Interleave i's count is `err_cnt[2i+1:2i]`. The walk starts at interleave 2 on the cycle after an accepted `field_end`.
- R8: `hw_corr` is set at each accepted `field_end` when `uncorr_in` is low, no count exceeds the limit and some count is non-zero. Otherwise it is cleared at that point. Resets also clear it.
- R9: `uncorr` sets at an accepted `field_end` with `uncorr_in` high. No walk follows it. It clears on either reset.
- R10: `seed_err` sets on `seed_err_in` and has no processor set path. It clears on `seed_w1c` or `rst_corr`.
- R11: While `rst_ecc` is high, all state is held in reset, configuration returns to limit 00 and warning 00, and `lfsr_clr` is high. `init_lfsr` raises `lfsr_clr` and leaves the status untouched.
- R12: `cfg_wr` is ignored while `busy` is high.
- R13: `busy` is high from an accepted `sec_start` until the walk ends or an uncorrectable `field_end` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_start | input | 1 | Start of sector correction |
| err_byte | input | 1 | One error byte seen this cycle |
| field_end | input | 1 | End of ECC field; decoder results valid |
| uncorr_in | input | 1 | Decoder judged sector uncorrectable |
| err_cnt | input | 6 | Per-interleave error counts, 2 bits each |
| seed_err_in | input | 1 | Seed error event |
| xfer_req | input | 1 | Transfer byte counter wants to advance |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | {warning threshold, correction limit} |
| log_th_wr | input | 1 | Log threshold write strobe |
| log_th_wdata | input | 4 | Log threshold value |
| rotate_wr | input | 1 | Software-correction acknowledge pulse |
| thexc_w1c | input | 1 | Clear threshold-exceeded flag |
| seed_w1c | input | 1 | Clear seed-error flag |
| rst_ecc | input | 1 | Full block reset, level |
| rst_corr | input | 1 | Correction reset, level |
| init_lfsr | input | 1 | LFSR initialise request, level |
| busy | output | 1 | Sector or correction in progress |
| curr_intl | output | 2 | Visited interleave, 3 = none |
| num_err | output | 2 | Error count of visited interleave |
| auto_fix | output | 1 | Automatic correction of visited interleave |
| sw_req | output | 1 | Software correction required |
| hw_corr | output | 1 | Sector correctable by hardware |
| uncorr | output | 1 | Sector uncorrectable |
| ewarn | output | 1 | Early warning hit |
| thexc | output | 1 | Log threshold exceeded |
| seed_err | output | 1 | Seed error flag |
| log_cnt | output | 4 | Error byte count of current sector |
| xfer_cnt_en | output | 1 | Transfer counter advance enable |
| lfsr_clr | output | 1 | LFSR clear request |

## Verification
Suppose the walk state or interleave pointer goes wrong. The next cycle after `field_end` or after a rotate then shows a wrong `curr_intl`/`num_err` pair, or an `auto_fix` on the wrong interleave. A missing or stuck stall shows as `sw_req` differing from the count-versus-limit comparison on the cycle after the visit. A bad tally or threshold register shows in `log_cnt` right away. It also shows in `thexc`, `hw_corr` or `ewarn` on the cycle after the field ends. The sweep covers every count pattern under every limit and warning setting, so one wrong comparison is exposed within a single sector.

// File: rtl/ecc_stat_pkg.sv
// Shared types and helpers for the interleaved ECC status controller.
// Assumes interleave counts are saturating codes (max value = "or more").
package ecc_stat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_WALK    = 2'd2,
        ST_STALL   = 2'd3
    } walk_state_e;

endpackage

// File: rtl/ecc_err_log.sv
// Per-sector error byte tally with a strict-greater log threshold flag.
// Assumes sec_go and field_go are already qualified by the walk FSM.
module ecc_err_log #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sec_go,
    input  logic          open,
    input  logic          err_byte,
    input  logic          field_go,
    input  logic          unc,
    input  logic [LW-1:0] log_th,
    input  logic          w1c,
    output logic [LW-1:0] log_cnt,
    output logic          thexc
);
    localparam logic [LW-1:0] CNT_MAX = '1;

    // Tally error bytes during the open sector, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || sec_go) begin
            log_cnt <= '0;
        end else if (open && err_byte && log_cnt != CNT_MAX) begin
            log_cnt <= log_cnt + 1'b1;
        end
    end

    // Latch threshold-exceeded at the end of a correctable sector.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            thexc <= 1'b0;
        end else if (field_go && !unc && log_cnt > log_th) begin
            thexc <= 1'b1;
        end else if (w1c) begin
            thexc <= 1'b0;
        end
    end

    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_go |=> log_cnt == '0);
    p_th_max_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thexc) |-> $past(log_th) != CNT_MAX);
endmodule

// File: rtl/ecc_sector_eval.sv
// Evaluates one sector's decoder result at end of field: hardware-
// correctable, uncorrectable and early-warning flags.
// Assumes err_cnt is valid in the field_go cycle.
module ecc_sector_eval #(
    parameter int NI = 3,
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             field_go,
    input  logic             unc,
    input  logic [NI*CW-1:0] err_cnt,
    input  logic [CW-1:0]    corr_th,
    input  logic [CW-1:0]    ew_th,
    output logic             hw_corr,
    output logic             uncorr,
    output logic             ewarn
);
    logic any_over, any_err, any_warn;

    // Reduce the per-interleave counts against both thresholds.
    always_comb begin
        any_over = 1'b0;
        any_err  = 1'b0;
        any_warn = 1'b0;
        for (int i = 0; i < NI; i++) begin
            if (err_cnt[i*CW +: CW] > corr_th)     any_over = 1'b1;
            if (err_cnt[i*CW +: CW] != '0)         any_err  = 1'b1;
            if (ew_th != '0 && err_cnt[i*CW +: CW] >= ew_th) any_warn = 1'b1;
        end
    end

    // Update sector flags when the decoder's result arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hw_corr <= 1'b0;
            uncorr  <= 1'b0;
            ewarn   <= 1'b0;
        end else if (field_go) begin
            hw_corr <= !unc && !any_over && any_err;
            uncorr  <= unc;
            if (!unc && any_warn) ewarn <= 1'b1;
        end
    end

    p_unc_not_hw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr |-> !hw_corr);
endmodule

// File: rtl/ecc_corr_walk.sv
// Correction walk FSM: visits interleaves NI-1 down to 0, pulses an
// automatic fix or stalls for software until a rotate acknowledge.
// Assumes err_cnt is held stable by the decoder during the walk.
module ecc_corr_walk
    import ecc_stat_pkg::*;
#(
    parameter int NI = 3,
    parameter int CW = 2,
    parameter int IW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sec_start,
    input  logic             field_end,
    input  logic             uncorr_in,
    input  logic [NI*CW-1:0] err_cnt,
    input  logic [CW-1:0]    corr_th,
    input  logic             rotate,
    output logic             sec_go,
    output logic             field_go,
    output logic             open,
    output logic             busy,
    output logic [IW-1:0]    cur,
    output logic [CW-1:0]    num_err,
    output logic             auto_fix,
    output logic             sw_req
);
    localparam logic [IW-1:0] IDLE_CODE = '1;
    localparam logic [IW-1:0] FIRST     = IW'(NI - 1);

    walk_state_e st;
    logic        over;

    // Select the visited interleave's count.
    always_comb begin
        num_err = '0;
        for (int i = 0; i < NI; i++) begin
            if (int'(cur) == i) num_err = err_cnt[i*CW +: CW];
        end
    end

    assign over     = num_err > corr_th;
    assign open     = (st == ST_COLLECT);
    assign busy     = (st != ST_IDLE);
    assign sec_go   = sec_start && (st == ST_IDLE || st == ST_COLLECT);
    assign field_go = field_end && open && !sec_start;
    assign auto_fix = (st == ST_WALK) && !over && num_err != '0;

    // Sequence the sector: collect, walk, stall on software handoff.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st     <= ST_IDLE;
            cur    <= IDLE_CODE;
            sw_req <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_COLLECT: begin
                    if (sec_go) begin
                        st <= ST_COLLECT;
                    end else if (field_go) begin
                        if (uncorr_in) begin
                            st <= ST_IDLE;
                        end else begin
                            st  <= ST_WALK;
                            cur <= FIRST;
                        end
                    end
                end
                ST_WALK: begin
                    if (over) begin
                        st     <= ST_STALL;
                        sw_req <= 1'b1;
                    end else if (cur == '0) begin
                        st  <= ST_IDLE;
                        cur <= IDLE_CODE;
                    end else begin
                        cur <= cur - 1'b1;
                    end
                end
                ST_STALL: begin
                    if (rotate) begin
                        sw_req <= 1'b0;
                        if (cur == '0) begin
                            st  <= ST_IDLE;
                            cur <= IDLE_CODE;
                        end else begin
                            st  <= ST_WALK;
                            cur <= cur - 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_idle_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cur == IDLE_CODE);
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL && !rotate && !clr) |=> (sw_req && $stable(cur)));
    p_rotate_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL && rotate) |=> !sw_req);
    p_no_fix_in_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> !auto_fix);
endmodule

// File: rtl/ecc_corr_status.sv
// Top of the interleaved ECC correction status controller: holds the
// processor configuration, seed flag and transfer gating, and ties the
// log, evaluation and walk pieces together.
// Assumes processor strobes are single-cycle and resets are levels.
module ecc_corr_status #(
    parameter int NI = 3,
    parameter int CW = 2,
    parameter int LW = 4,
    parameter int IW = $clog2(NI + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_start,
    input  logic             err_byte,
    input  logic             field_end,
    input  logic             uncorr_in,
    input  logic [NI*CW-1:0] err_cnt,
    input  logic             seed_err_in,
    input  logic             xfer_req,
    input  logic             cfg_wr,
    input  logic [2*CW-1:0]  cfg_wdata,
    input  logic             log_th_wr,
    input  logic [LW-1:0]    log_th_wdata,
    input  logic             rotate_wr,
    input  logic             thexc_w1c,
    input  logic             seed_w1c,
    input  logic             rst_ecc,
    input  logic             rst_corr,
    input  logic             init_lfsr,
    output logic             busy,
    output logic [IW-1:0]    curr_intl,
    output logic [CW-1:0]    num_err,
    output logic             auto_fix,
    output logic             sw_req,
    output logic             hw_corr,
    output logic             uncorr,
    output logic             ewarn,
    output logic             thexc,
    output logic             seed_err,
    output logic [LW-1:0]    log_cnt,
    output logic             xfer_cnt_en,
    output logic             lfsr_clr
);
    logic [2*CW-1:0] cfg_q;
    logic [LW-1:0]   log_th_q;
    logic            corr_clr, sec_go, field_go, open;

    assign corr_clr = rst_ecc || rst_corr;

    // Configuration register, frozen while the block is busy.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_ecc) begin
            cfg_q <= '0;
        end else if (cfg_wr && !busy) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Log threshold register; resets to the disabling value.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_ecc) begin
            log_th_q <= '1;
        end else if (log_th_wr) begin
            log_th_q <= log_th_wdata;
        end
    end

    // Seed error flag: hardware set, processor write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n || corr_clr) begin
            seed_err <= 1'b0;
        end else if (seed_err_in) begin
            seed_err <= 1'b1;
        end else if (seed_w1c) begin
            seed_err <= 1'b0;
        end
    end

    assign xfer_cnt_en = xfer_req && !sw_req;
    assign lfsr_clr    = init_lfsr || rst_ecc;

    ecc_corr_walk #(.NI(NI), .CW(CW), .IW(IW)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(corr_clr),
        .sec_start(sec_start), .field_end(field_end), .uncorr_in(uncorr_in),
        .err_cnt(err_cnt), .corr_th(cfg_q[CW-1:0]), .rotate(rotate_wr),
        .sec_go(sec_go), .field_go(field_go), .open(open), .busy(busy),
        .cur(curr_intl), .num_err(num_err), .auto_fix(auto_fix),
        .sw_req(sw_req)
    );

    ecc_err_log #(.LW(LW)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(corr_clr), .sec_go(sec_go),
        .open(open), .err_byte(err_byte), .field_go(field_go),
        .unc(uncorr_in), .log_th(log_th_q), .w1c(thexc_w1c),
        .log_cnt(log_cnt), .thexc(thexc)
    );

    ecc_sector_eval #(.NI(NI), .CW(CW)) u_eval (
        .clk(clk), .rst_n(rst_n), .clr(corr_clr), .field_go(field_go),
        .unc(uncorr_in), .err_cnt(err_cnt), .corr_th(cfg_q[CW-1:0]),
        .ew_th(cfg_q[2*CW-1:CW]), .hw_corr(hw_corr), .uncorr(uncorr),
        .ewarn(ewarn)
    );

    p_hw_not_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_corr |-> !sw_req);
    p_sw_implies_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> busy);
    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rst_ecc) |=> $stable(cfg_q));
    p_full_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ecc |=> (!busy && !sw_req && !uncorr && !seed_err));
endmodule

// File: tb/sim_ecc_corr_status.sv
module sim_ecc_corr_status;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       sec_start = 0, err_byte = 0, field_end = 0, uncorr_in = 0;
    logic [5:0] err_cnt = '0;
    logic       seed_err_in = 0, xfer_req = 1, cfg_wr = 0;
    logic [3:0] cfg_wdata = '0;
    logic       log_th_wr = 0;
    logic [3:0] log_th_wdata = '0;
    logic       rotate_wr = 0, thexc_w1c = 0, seed_w1c = 0;
    logic       rst_ecc = 0, rst_corr = 0, init_lfsr = 0;
    logic       busy, auto_fix, sw_req, hw_corr, uncorr, ewarn, thexc;
    logic       seed_err, xfer_cnt_en, lfsr_clr;
    logic [1:0] curr_intl, num_err;
    logic [3:0] log_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    ecc_corr_status u0 (.*);

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(int ew, int th, int lt);
        cfg_wdata = 4'((ew << 2) | th); cfg_wr = 1;
        log_th_wdata = 4'(lt); log_th_wr = 1;
        cyc();
        cfg_wr = 0; log_th_wr = 0;
    endtask

    task automatic pulse_rst_corr();
        rst_corr = 1; cyc(); rst_corr = 0;
    endtask

    // Open a sector, feed k error bytes, end the field.
    task automatic open_fill_end(int c, int k, bit unc);
        err_cnt = 6'(c);
        sec_start = 1; cyc(); sec_start = 0;
        chk("R13 busy after start", busy, 1);
        chk("R1 count cleared at start", log_cnt, 0);
        if (k > 0) begin
            err_byte = 1; repeat (k) cyc(); err_byte = 0;
        end
        chk("R1 tally", log_cnt, (k > 15) ? 15 : k);
        field_end = 1; uncorr_in = unc; cyc(); field_end = 0; uncorr_in = 0;
    endtask

    // Walk through the interleaves, checking each visit.
    task automatic walk(int c, int th);
        for (int i = 2; i >= 0; i--) begin
            int n;
            n = (c >> (2 * i)) & 3;
            chk("R7 curr_intl", curr_intl, i);
            chk("R7 num_err", num_err, n);
            chk("R4 auto_fix", auto_fix, (n != 0 && n <= th) ? 1 : 0);
            if (n > th) begin
                cyc();
                chk("R5 sw_req set", sw_req, 1);
                chk("R5 stall holds interleave", curr_intl, i);
                chk("R5 transfer blocked", xfer_cnt_en, 0);
                rotate_wr = 1; cyc(); rotate_wr = 0;
                chk("R6 rotate releases", sw_req, 0);
            end else begin
                cyc();
            end
        end
        chk("R7 idle code after walk", curr_intl, 3);
        chk("R13 not busy after walk", busy, 0);
        chk("R5 transfer enabled", xfer_cnt_en, 1);
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1; cyc();
        chk("R7 reset curr_intl", curr_intl, 3);
        chk("R13 reset busy", busy, 0);
        chk("R1 reset log_cnt", log_cnt, 0);
        chk("R8 reset hw_corr", hw_corr, 0);
        chk("R5 reset sw_req", sw_req, 0);

        // Sweep every count pattern under every limit and warning level.
        for (int th = 0; th < 4; th++) begin
            for (int ew = 0; ew < 4; ew++) begin
                for (int c = 0; c < 64; c++) begin
                    int lt, k, mx, anyerr;
                    bit unc;
                    lt = (c + 3 * ew + th) % 16;
                    k = (c * 5 + ew + th) % 16;
                    unc = ((c + th) % 7) == 3;
                    mx = 0; anyerr = 0;
                    for (int i = 0; i < 3; i++) begin
                        int n;
                        n = (c >> (2 * i)) & 3;
                        if (n > mx) mx = n;
                        if (n != 0) anyerr = 1;
                    end
                    set_cfg(ew, th, lt);
                    pulse_rst_corr();
                    open_fill_end(c, k, unc);
                    chk("R9 uncorr", uncorr, unc ? 1 : 0);
                    chk("R8 hw_corr", hw_corr, (!unc && mx <= th && anyerr) ? 1 : 0);
                    chk("R3 ewarn", ewarn, (!unc && ew != 0 && mx >= ew) ? 1 : 0);
                    chk("R2 thexc", thexc, (!unc && k > lt) ? 1 : 0);
                    if (unc) begin
                        chk("R9 no walk", busy, 0);
                        chk("R9 idle code", curr_intl, 3);
                    end else begin
                        walk(c, th);
                    end
                end
            end
        end

        // R1 saturation and R2 threshold 15 never fires.
        set_cfg(0, 3, 15); pulse_rst_corr();
        open_fill_end(0, 20, 0);
        chk("R2 threshold 15 disables", thexc, 0);
        walk(0, 3);
        // R2 write-1 clear.
        set_cfg(0, 3, 2); pulse_rst_corr();
        open_fill_end(0, 5, 0);
        chk("R2 thexc set", thexc, 1);
        walk(0, 3);
        thexc_w1c = 1; cyc(); thexc_w1c = 0;
        chk("R2 thexc w1c", thexc, 0);
        // R8 next sector re-evaluates hw_corr.
        set_cfg(0, 1, 15); pulse_rst_corr();
        open_fill_end(6'b010000, 1, 0);
        walk(6'b010000, 1);
        chk("R8 hw_corr held after walk", hw_corr, 1);
        open_fill_end(0, 0, 0);
        chk("R8 hw_corr cleared by next sector", hw_corr, 0);
        walk(0, 1);
        // R10 seed flag.
        seed_err_in = 1; cyc(); seed_err_in = 0;
        chk("R10 seed set", seed_err, 1);
        seed_w1c = 1; cyc(); seed_w1c = 0;
        chk("R10 seed w1c", seed_err, 0);
        seed_err_in = 1; cyc(); seed_err_in = 0;
        pulse_rst_corr();
        chk("R10 seed cleared by rst_corr", seed_err, 0);
        // R11 init_lfsr leaves status alone.
        seed_err_in = 1; cyc(); seed_err_in = 0;
        init_lfsr = 1; cyc();
        chk("R11 lfsr_clr on init", lfsr_clr, 1);
        init_lfsr = 0; cyc();
        chk("R11 init keeps seed", seed_err, 1);
        chk("R11 lfsr_clr released", lfsr_clr, 0);
        // R12 config write ignored while busy: limit stays 1.
        set_cfg(0, 1, 15); pulse_rst_corr();
        err_cnt = 6'b100000;
        sec_start = 1; cyc(); sec_start = 0;
        cfg_wdata = 4'b0011; cfg_wr = 1; cyc(); cfg_wr = 0;
        field_end = 1; cyc(); field_end = 0;
        cyc();
        chk("R12 busy write ignored", sw_req, 1);
        rotate_wr = 1; cyc(); rotate_wr = 0;
        cyc(); cyc();
        chk("R12 walk ended", busy, 0);
        // R11 full reset: config back to limit 0, held while set.
        set_cfg(0, 3, 15);
        rst_ecc = 1; cyc();
        sec_start = 1; cyc(); sec_start = 0;
        chk("R11 start ignored in reset", busy, 0);
        chk("R11 lfsr_clr in reset", lfsr_clr, 1);
        chk("R11 seed cleared", seed_err, 0);
        rst_ecc = 0; cyc();
        open_fill_end(6'b010000, 0, 0);
        chk("R11 limit reset to 0 (no hw)", hw_corr, 0);
        walk(6'b010000, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule